// File: doc/BRIEF.md
# PS/2 Port Register Interface

This block is the host-facing register set for a single keyboard or mouse port. A processor reaches it over a simple synchronous word bus inside a 4 KB window. Through that bus, software can write a control word, keep a clock divisor value, see receive status and the parity of the last byte it fetched, fetch received bytes and send bytes to the device. A read-only table of eight identification bytes sits at the top of the window.

On the device side, a byte source raises a valid flag while it holds a byte. The block takes that byte only when software reads the data register, and it pulses an acknowledge in the same cycle so the source can move to its next byte. A write to the data register forwards the low byte to the device with a one-cycle strobe. A level interrupt output combines a receive-gated enable with an unconditional force bit, both taken from the control word. The wire-level serializer and the device itself sit outside this block.

Top module: `ps2_port_regs`

## Requirements
- R1: The control word (byte offset 0x00) and the divisor word (byte offset 0x0C) store all 32 written bits and read them back unchanged. The divisor has no other effect.
- R2: A read at byte offset 0xFE0 + 4*i, for i = 0 to 7, returns the i-th entry of the identification list 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0, with the upper bits zero.
- R3: A status read (offset 0x04) returns bit 6 = 1, bit 4 = the device valid flag, bit 2 = the XOR of all eight bits of the held data byte, and zero in every other bit.
- R4: The interrupt output equals (device valid AND control bit 4) OR control bit 3. It follows a control write from the very next cycle.
- R5: A data read (offset 0x08) while the device valid flag is high returns the device's offered byte, stores it as the held byte, and raises the acknowledge for exactly that request cycle.
- R6: A data read while valid is low returns the held byte, leaves it unchanged and raises no acknowledge.
- R7: An interrupt-status read (offset 0x10) returns the valid flag in bit 0 and a constant 1 in bit 1, with zero elsewhere.
- R8: A data-register write raises the transmit strobe for one cycle after the write edge and presents bits 7:0 of the written word on the transmit byte.
- R9: After reset, control, divisor and held byte are zero, the interrupt is low and the transmit strobe is low.
- R10: A read at any other offset, or at any address whose two low bits are not zero, returns zero. A write anywhere other than control, divisor or data changes no register and raises no strobe.
- R11: Read data appears on the clock edge that samples the request and holds until the next request. A write takes effect on the edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_rx_valid | input | 1 | Device holds a byte for the host |
| dev_rx_byte | input | 8 | Byte offered by the device |
| dev_rx_ack | output | 1 | Byte taken this cycle |
| dev_tx_strobe | output | 1 | One-cycle transmit pulse |
| dev_tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The parity bit is the hardest part to cover, because it can only reflect a byte that software has actually fetched from the device. To reach every value, the bench's device model offers a byte sequence k*37+5 mod 256. That sequence visits all 256 values in turn. The bench fetches each one through the data register and then reads status and interrupt status to compare bit 2 with a bit count done in the bench. The interrupt equation is swept over all four control-bit combinations, each with valid both high and low. A full sweep of every word address runs while nothing is pending, so that the data read cannot consume a byte.

// File: rtl/ps2_port_pkg.sv
package ps2_port_pkg;

    localparam int unsigned ID_WORDS = 8;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_DATA,
        SEL_CDIV,
        SEL_ISTAT,
        SEL_ID
    } reg_sel_e;

    // Control bit positions used by the interrupt combiner
    localparam int unsigned CTRL_FORCE_BIT = 3;
    localparam int unsigned CTRL_RXEN_BIT  = 4;

    // Status bit positions
    localparam int unsigned STAT_PAR_BIT   = 2;
    localparam int unsigned STAT_FULL_BIT  = 4;
    localparam int unsigned STAT_EMPTY_BIT = 6;

    function automatic logic [7:0] id_byte(input logic [2:0] idx);
        logic [7:0] b;
        case (idx)
            3'd0:    b = 8'h50;
            3'd1:    b = 8'h10;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ps2_addr_dec.sv
module ps2_addr_dec
    import ps2_port_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]           addr,
    output reg_sel_e                    sel,
    output logic [$clog2(ID_WORDS)-1:0] id_idx
);
    localparam int IDX_W   = $clog2(ID_WORDS);
    localparam int WIN_LSB = IDX_W + 2;
    localparam int REG_LSB = 5;

    always_comb begin
        sel    = SEL_NONE;
        id_idx = addr[WIN_LSB-1:2];
        if (addr[1:0] == 2'b00) begin
            if (&addr[ADDR_W-1:WIN_LSB]) begin
                sel = SEL_ID;
            end else if (addr[ADDR_W-1:REG_LSB] == '0) begin
                case (addr[REG_LSB-1:2])
                    3'd0:    sel = SEL_CTRL;
                    3'd1:    sel = SEL_STAT;
                    3'd2:    sel = SEL_DATA;
                    3'd3:    sel = SEL_CDIV;
                    3'd4:    sel = SEL_ISTAT;
                    default: sel = SEL_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_data_req,
    input  logic       dev_rx_valid,
    input  logic [7:0] dev_rx_byte,
    output logic       dev_rx_ack,
    output logic [7:0] fetch_byte,
    output logic [7:0] held_byte,
    output logic       held_parity
);
    typedef struct packed {
        logic [7:0] last;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        dev_rx_ack = rd_data_req && dev_rx_valid;
        if (dev_rx_ack) begin
            st_d.last = dev_rx_byte;
        end
        fetch_byte  = st_d.last;
        held_byte   = st_q.last;
        held_parity = ^st_q.last;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_fetch_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rx_ack |=> held_byte == $past(dev_rx_byte));

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rx_ack |=> $stable(held_byte));
endmodule

// File: rtl/ps2_ctrl_irq.sv
module ps2_ctrl_irq
    import ps2_port_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cdiv,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pending,
    output logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] cdiv,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic              irq
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cdiv;
        logic              tx_stb;
        logic [7:0]        tx_byte;
    } ci_state_t;

    ci_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.tx_stb = 1'b0;
        if (wr_ctrl) st_d.ctrl = wdata;
        if (wr_cdiv) st_d.cdiv = wdata;
        if (wr_data) begin
            st_d.tx_stb  = 1'b1;
            st_d.tx_byte = wdata[7:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl      = st_q.ctrl;
    assign cdiv      = st_q.cdiv;
    assign tx_strobe = st_q.tx_stb;
    assign tx_byte   = st_q.tx_byte;
    assign irq       = (pending && st_q.ctrl[CTRL_RXEN_BIT]) || st_q.ctrl[CTRL_FORCE_BIT];

    p_force_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_FORCE_BIT]) |=> irq);

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(wr_data));

    p_cdiv_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cdiv |=> $stable(cdiv));
endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
    import ps2_port_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dev_rx_valid,
    input  logic [7:0]        dev_rx_byte,
    output logic              dev_rx_ack,
    output logic              dev_tx_strobe,
    output logic [7:0]        dev_tx_byte,
    output logic              irq
);
    localparam int IDX_W = $clog2(ID_WORDS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  id_idx;
    logic              rd, wr;
    logic [7:0]        fetch_byte, held_byte;
    logic              held_parity;
    logic [DATA_W-1:0] ctrl, cdiv;

    assign rd = bus_sel && !bus_wr;
    assign wr = bus_sel &&  bus_wr;

    ps2_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .id_idx (id_idx)
    );

    ps2_rx_hold u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_data_req  (rd && sel == SEL_DATA),
        .dev_rx_valid (dev_rx_valid),
        .dev_rx_byte  (dev_rx_byte),
        .dev_rx_ack   (dev_rx_ack),
        .fetch_byte   (fetch_byte),
        .held_byte    (held_byte),
        .held_parity  (held_parity)
    );

    ps2_ctrl_irq #(.DATA_W(DATA_W)) u_ci (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr && sel == SEL_CTRL),
        .wr_cdiv   (wr && sel == SEL_CDIV),
        .wr_data   (wr && sel == SEL_DATA),
        .wdata     (bus_wdata),
        .pending   (dev_rx_valid),
        .ctrl      (ctrl),
        .cdiv      (cdiv),
        .tx_strobe (dev_tx_strobe),
        .tx_byte   (dev_tx_byte),
        .irq       (irq)
    );

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.rdata = '0;
            case (sel)
                SEL_CTRL: st_d.rdata = ctrl;
                SEL_CDIV: st_d.rdata = cdiv;
                SEL_DATA: st_d.rdata[7:0] = fetch_byte;
                SEL_STAT: begin
                    st_d.rdata[STAT_EMPTY_BIT] = 1'b1;
                    st_d.rdata[STAT_FULL_BIT]  = dev_rx_valid;
                    st_d.rdata[STAT_PAR_BIT]   = held_parity;
                end
                SEL_ISTAT: begin
                    st_d.rdata[1] = 1'b1;
                    st_d.rdata[0] = dev_rx_valid;
                end
                SEL_ID:   st_d.rdata[7:0] = id_byte(id_idx);
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_NONE) |=> bus_rdata == '0);

    p_stat_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_STAT) |=> (bus_rdata[STAT_EMPTY_BIT] && !bus_rdata[5]
                                     && !bus_rdata[3] && !bus_rdata[1] && !bus_rdata[0]));

    p_istat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == SEL_ISTAT) |=> (bus_rdata[1] && bus_rdata[0] == $past(dev_rx_valid)));

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_ps2_port_regs.sv
module tb_ps2_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dev_rx_valid;
    logic [7:0]  dev_rx_byte;
    logic        dev_rx_ack;
    logic        dev_tx_strobe;
    logic [7:0]  dev_tx_byte;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int dev_idx = 0;
    int dev_lim = 0;

    always #4 clk = ~clk;

    ps2_port_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_rx_valid(dev_rx_valid), .dev_rx_byte(dev_rx_byte), .dev_rx_ack(dev_rx_ack),
        .dev_tx_strobe(dev_tx_strobe), .dev_tx_byte(dev_tx_byte), .irq(irq)
    );

    // Device model: byte k is k*37+5 mod 256 (visits all 256 values)
    function automatic logic [7:0] dev_val(input int k);
        return 8'((k * 37 + 5) % 256);
    endfunction
    assign dev_rx_valid = dev_idx < dev_lim;
    assign dev_rx_byte  = dev_val(dev_idx);
    always @(posedge clk) begin
        if (!rst_n) dev_idx <= 0;
        else if (dev_rx_ack) dev_idx <= dev_idx + 1;
    end

    function automatic logic bit_par(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(v[i]);
        return logic'(c % 2);
    endfunction

    function automatic logic [7:0] id_exp(input int i);
        logic [7:0] t;
        case (i)
            0: t = 8'h50; 1: t = 8'h10; 2: t = 8'h04; 3: t = 8'h00;
            4: t = 8'h0D; 5: t = 8'hF0; 6: t = 8'h05; default: t = 8'hB1;
        endcase
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] rd_val;
    logic        ack_seen;
    logic        stb_seen;
    logic [7:0]  stb_byte;

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 ack_seen = dev_rx_ack;
        @(negedge clk);
        bus_sel = 1'b0;
        rd_val = bus_rdata;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        stb_seen = dev_tx_strobe; stb_byte = dev_tx_byte;
    endtask

    function automatic logic [31:0] exp_read(input int a, input logic [31:0] c,
                                             input logic [31:0] d, input logic [7:0] last);
        if (a % 4 != 0) return 32'h0;
        if (a >= 12'hFE0) return {24'h0, id_exp((a - 12'hFE0) / 4)};
        case (a)
            0:  return c;
            4:  return 32'h40 | (32'(bit_par(last)) << 2);
            8:  return {24'h0, last};
            12: return d;
            16: return 32'h2;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  last = 8'h00;
        logic [31:0] cval = 32'h0;
        logic [31:0] dval = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 irq", 32'(irq), 0);
        check("R9 tx_strobe", 32'(dev_tx_strobe), 0);
        bus_read(12'h000); check("R9 ctrl", rd_val, 0);
        bus_read(12'h00C); check("R9 cdiv", rd_val, 0);
        bus_read(12'h008); check("R9 data", rd_val, 0);
        bus_read(12'h004); check("R9 status", rd_val, 32'h40);

        // R1 / R11 storage
        bus_write(12'h000, 32'hA5A5_5A42); cval = 32'hA5A5_5A42;
        bus_read(12'h000); check("R1 ctrl", rd_val, cval);
        bus_write(12'h00C, 32'h1234_5678); dval = 32'h1234_5678;
        bus_read(12'h00C); check("R1 cdiv", rd_val, dval);
        check("R11 rdata holds", bus_rdata, dval);

        // R4 interrupt sweep: 4 control combos x pending
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                bus_write(12'h000, 32'(c) << 3);
                dev_lim = dev_idx + p;
                #1 check("R4 irq", 32'(irq), 32'((p == 1 && c[1]) || c[0]));
            end
        end
        dev_lim = dev_idx;
        bus_write(12'h000, 32'h0); cval = 0;

        // R5/R3/R7 fetch sweep over all byte values
        for (int k = 0; k < 256; k++) begin
            logic [7:0] e;
            dev_lim = dev_idx + 2;
            e = dev_val(dev_idx);
            bus_read(12'h008);
            check("R5 data", rd_val, {24'h0, e});
            check("R5 ack", 32'(ack_seen), 1);
            last = e;
            bus_read(12'h004);
            check("R3 status", rd_val, 32'h50 | (32'(bit_par(e)) << 2));
            bus_read(12'h010);
            check("R7 istat", rd_val, 32'h3);
        end
        dev_lim = dev_idx;

        // R6 no pending
        bus_read(12'h008);
        check("R6 data", rd_val, {24'h0, last});
        check("R6 ack", 32'(ack_seen), 0);
        bus_read(12'h004);
        check("R3 status idle", rd_val, 32'h40 | (32'(bit_par(last)) << 2));
        bus_read(12'h010);
        check("R7 istat idle", rd_val, 32'h2);

        // R8 transmit
        bus_write(12'h008, 32'h0001_F03C);
        check("R8 strobe", 32'(stb_seen), 1);
        check("R8 byte", 32'(stb_byte), 32'h3C);
        @(negedge clk);
        check("R8 one cycle", 32'(dev_tx_strobe), 0);
        bus_read(12'h008);
        check("R8 held untouched", rd_val, {24'h0, last});

        // R10 ignored writes
        bus_write(12'h004, 32'hFFFF_FFFF); check("R10 stat write strobe", 32'(stb_seen), 0);
        bus_write(12'h010, 32'hFFFF_FFFF); check("R10 istat write strobe", 32'(stb_seen), 0);
        bus_write(12'hFE4, 32'hFFFF_FFFF); check("R10 id write strobe", 32'(stb_seen), 0);
        bus_write(12'h014, 32'hFFFF_FFFF);
        bus_write(12'h801, 32'hFFFF_FFFF);
        bus_write(12'h00A, 32'hFFFF_FFFF); check("R10 misaligned data strobe", 32'(stb_seen), 0);
        bus_write(12'h002, 32'hFFFF_FFFF);
        check("R10 irq unchanged", 32'(irq), 0);
        bus_read(12'h000); check("R10 ctrl unchanged", rd_val, cval);
        bus_read(12'h00C); check("R10 cdiv unchanged", rd_val, dval);

        // R2/R10 full address sweep, every byte address, nothing pending
        for (int a = 0; a < 4096; a++) begin
            bus_read(12'(a));
            check((a >= 12'hFE0) ? "R2 id" : "R10 map", rd_val, exp_read(a, cval, dval, last));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule